// File: doc/BRIEF.md
# Transport Stream Capture Ring Writer

The block receives a byte-wide MPEG transport stream, one byte per cycle when `ts_valid` is high, with `ts_start` marking the first byte of each packet. It stores packet-aligned data into a circular region of memory through a simple byte write port. The address of each write is the programmed base address plus a running offset. The offset returns to zero when it reaches the programmed ring length. Capture begins only on a sync byte (0x47) that arrives together with the start strobe, so every stored packet opens with its sync byte.

A small register file, accessed as word indices on `reg_addr`, configures the ring and reports progress. Software programs the base address, the ring length, the packet length and how many whole packets are stored between stream interrupts. It reads the live write position back as an absolute address. It can restart the ring at its base. An interrupt status register with write-one-to-clear semantics collects the stream event and two external event inputs. A mask register gates each status bit onto `irq`.

Top module: `ts_ring_writer`

## Requirements
- R1: After reset: the run bit (index 0) reads 0, packet length (index 3) reads 188, packets-per-interrupt (index 4) reads 47, base (index 1) reads 0, the write position (index 5) reads 0, status (index 8) reads 0 and `irq` is 0.
- R2: While control bit 0 (index 0) is 0, no byte is written and the write position does not move.
- R3: Outside a packet, a byte is stored only if `ts_start` is 1 and the data is 0x47. Any other byte is discarded.
- R4: Each stored byte is written at base plus offset, and the offset then advances by one. When the advanced offset equals the ring length (index 2), it becomes 0.
- R5: Once packet-length bytes of a packet have been stored, the next packet again needs the sync condition of R3. Bytes in between are discarded.
- R6: The write-position register (index 5, read only) returns base plus the current offset.
- R7: Writing a 1 in bit 0 of the restart register (index 6) sets the offset to 0, abandons any partial packet and clears the packet count. A byte presented in that same cycle is dropped.
- R8: Each completed packet increments a packet count. When the count reaches the packets-per-interrupt value, status bit 0 is set and the count restarts.
- R9: Status (index 8) has bit 0 for stream data, bit 2 set by a `host_evt` pulse and bit 3 set by an `ir_evt` pulse. Writing 1 to a bit clears it. A bit set in the same cycle as its clear stays set.
- R10: `irq` equals control bit 0 ANDed with the OR of status ANDed with the mask register (index 7, same bit positions).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ts_data | input | 8 | Stream byte |
| ts_valid | input | 1 | Byte valid strobe |
| ts_start | input | 1 | Packet start strobe |
| host_evt | input | 1 | Host event pulse, sets status bit 2 |
| ir_evt | input | 1 | Remote-control event pulse, sets status bit 3 |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_we | output | 1 | Memory byte write enable |
| mem_addr | output | 32 | Memory byte address |
| mem_data | output | 8 | Memory byte data |
| irq | output | 1 | Interrupt request |

## Verification
Suppose the byte counter or the packet flag goes wrong. The damage shows within one packet: a sync byte is missed, or a non-sync byte opens a packet, and `mem_we` disagrees with the model on that very byte. A wrong offset appears at once on `mem_addr` and in the write-position readback. A fault at the wrap point is exposed on the first byte after the ring length is reached. A fault in the packet count or in the status update shows on `irq` in the cycle after the packet that should or should not have completed an interrupt group. It also shows in the cycle of a simultaneous set and clear.

// File: rtl/ts_ring_writer.sv
module ts_ring_writer #(
  parameter int AW           = 32,
  parameter int LW           = 24,
  parameter int DW           = 32,
  parameter int DEF_PKT_LEN  = 188,
  parameter int DEF_IRQ_PKTS = 47,
  parameter int DEF_RING_LEN = 44180
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [7:0]    ts_data,
  input  logic          ts_valid,
  input  logic          ts_start,
  input  logic          host_evt,
  input  logic          ir_evt,
  input  logic          reg_wr,
  input  logic [3:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_data,
  output logic          irq
);
  localparam logic [3:0] IX_CTRL = 4'd0, IX_BASE = 4'd1, IX_RING = 4'd2,
                         IX_PLEN = 4'd3, IX_NIRQ = 4'd4, IX_WPOS = 4'd5,
                         IX_RSTR = 4'd6, IX_MASK = 4'd7, IX_STAT = 4'd8;

  logic          run, in_pkt;
  logic [AW-1:0] base;
  logic [LW-1:0] ring, plen, nirq, off, bcnt, pkcnt;
  logic [3:0]    mask, status;

  logic          sync_hit, restart_hit, take, done, pk_full, ts_set;
  logic [LW-1:0] cnt_nxt, off_nxt, pk_nxt;
  logic [3:0]    st_clr, st_set, st_nxt;

  assign sync_hit    = ts_start && (ts_data == 8'h47);
  assign restart_hit = reg_wr && (reg_addr == IX_RSTR) && reg_wdata[0];
  assign take        = run && ts_valid && (in_pkt || sync_hit) && !restart_hit;
  assign cnt_nxt     = in_pkt ? bcnt + LW'(1) : LW'(1);
  assign done        = (cnt_nxt == plen);
  assign pk_nxt      = pkcnt + LW'(1);
  assign pk_full     = (pk_nxt >= nirq);
  assign off_nxt     = (off + LW'(1) == ring) ? '0 : off + LW'(1);
  assign ts_set      = take && done && pk_full;

  assign st_clr = (reg_wr && reg_addr == IX_STAT) ? reg_wdata[3:0] : 4'b0000;
  assign st_set = {ir_evt, host_evt, 1'b0, ts_set};
  assign st_nxt = (status & ~st_clr) | st_set;

  assign mem_we   = take;
  assign mem_addr = base + AW'(off);
  assign mem_data = ts_data;
  assign irq      = run && |(status & mask);

  always_comb begin
    case (reg_addr)
      IX_CTRL: reg_rdata = DW'(run);
      IX_BASE: reg_rdata = DW'(base);
      IX_RING: reg_rdata = DW'(ring);
      IX_PLEN: reg_rdata = DW'(plen);
      IX_NIRQ: reg_rdata = DW'(nirq);
      IX_WPOS: reg_rdata = DW'(mem_addr);
      IX_MASK: reg_rdata = DW'(mask);
      IX_STAT: reg_rdata = DW'(status);
      default: reg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run    <= 1'b0;
      base   <= '0;
      ring   <= LW'(DEF_RING_LEN);
      plen   <= LW'(DEF_PKT_LEN);
      nirq   <= LW'(DEF_IRQ_PKTS);
      mask   <= 4'b0000;
      status <= 4'b0000;
      off    <= '0;
      bcnt   <= '0;
      pkcnt  <= '0;
      in_pkt <= 1'b0;
    end else begin
      if (reg_wr) begin
        case (reg_addr)
          IX_CTRL: run  <= reg_wdata[0];
          IX_BASE: base <= reg_wdata[AW-1:0];
          IX_RING: ring <= reg_wdata[LW-1:0];
          IX_PLEN: plen <= reg_wdata[LW-1:0];
          IX_NIRQ: nirq <= reg_wdata[LW-1:0];
          IX_MASK: mask <= reg_wdata[3:0];
          default: ;
        endcase
      end
      if (restart_hit) begin
        off    <= '0;
        bcnt   <= '0;
        pkcnt  <= '0;
        in_pkt <= 1'b0;
      end else if (take) begin
        off    <= off_nxt;
        in_pkt <= !done;
        bcnt   <= done ? '0 : cnt_nxt;
        if (done) pkcnt <= pk_full ? '0 : pk_nxt;
      end
      status <= st_nxt;
    end
  end

  // R2: writes only happen while running
  a_r2_no_write_idle: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> run);
  // R3: a new packet only opens on sync byte with start strobe
  a_r3_sync_first: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && !in_pkt) |-> (ts_start && ts_data == 8'h47));
  // R4: offset returns to zero at the ring length
  a_r4_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (take && off + LW'(1) == ring) |=> (off == '0));
  // R7: restart puts the write position back at the base
  a_r7_restart: assert property (@(posedge clk) disable iff (!rst_n)
    restart_hit |=> (mem_addr == base && !in_pkt));
  // R9: a set in the same cycle as a clear wins
  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    host_evt |=> status[2]);
  // R8: completing an interrupt group raises stream status
  a_r8_ts_status: assert property (@(posedge clk) disable iff (!rst_n)
    ts_set |=> status[0]);
  // R10: no interrupt while stopped
  a_r10_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> run);
endmodule

// File: tb/ts_ring_writer_tb_top.sv
module ts_ring_writer_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] ts_data = 8'h00;
  logic ts_valid = 1'b0, ts_start = 1'b0, host_evt = 1'b0, ir_evt = 1'b0;
  logic reg_wr = 1'b0;
  logic [3:0] reg_addr = 4'd5;
  logic [31:0] reg_wdata = '0, reg_rdata, mem_addr;
  logic mem_we, irq;
  logic [7:0] mem_data;

  always #10 clk = ~clk;

  ts_ring_writer dut_i (
    .clk(clk), .rst_n(rst_n), .ts_data(ts_data), .ts_valid(ts_valid),
    .ts_start(ts_start), .host_evt(host_evt), .ir_evt(ir_evt),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_data(mem_data), .irq(irq));

  int n_chk = 0, n_bad = 0;
  bit done_flag = 1'b0;

  // reference model state
  bit m_run = 0, m_in = 0;
  int unsigned m_base = 0, m_ring = 44180, m_plen = 188, m_nirq = 47;
  int unsigned m_off = 0, m_b = 0, m_pk = 0;
  logic [3:0] m_mask = 0, m_st = 0;

  function automatic bit exp_irq();
    return m_run && |(m_st & m_mask);
  endfunction

  function automatic int unsigned exp_pos();
    return m_base + m_off;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d, input bit hev = 0);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d; host_evt = hev;
    @(posedge clk);
    #1;
    reg_wr = 0; reg_addr = 4'd5; host_evt = 0;
    case (a)
      0: m_run = d[0];
      1: m_base = d;
      2: m_ring = d[23:0];
      3: m_plen = d[23:0];
      4: m_nirq = d[23:0];
      6: if (d[0]) begin m_off = 0; m_b = 0; m_pk = 0; m_in = 0; end
      7: m_mask = d[3:0];
      8: m_st = m_st & ~d[3:0];
      default: ;
    endcase
    if (hev) m_st[2] = 1'b1;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    @(negedge clk);
    reg_addr = a;
    #2 v = reg_rdata;
    reg_addr = 4'd5;
  endtask

  task automatic send(input logic [7:0] d, input bit v, input bit s, input string req);
    bit we;
    @(negedge clk);
    ts_data = d; ts_valid = v; ts_start = s;
    #5;
    we = m_run && v && (m_in || (s && d == 8'h47));
    chk(mem_we == we, req, 32'(mem_we), 32'(we));
    if (we) begin
      chk(mem_addr == exp_pos(), {req, " R4 addr"}, mem_addr, exp_pos());
      chk(mem_data == d, {req, " data"}, 32'(mem_data), 32'(d));
    end
    @(posedge clk);
    #1;
    ts_valid = 0; ts_start = 0;
    if (we) begin
      m_off = (m_off + 1 == m_ring) ? 0 : m_off + 1;
      m_b = m_in ? m_b + 1 : 1;
      m_in = 1;
      if (m_b == m_plen) begin
        m_in = 0; m_b = 0; m_pk++;
        if (m_pk >= m_nirq) begin m_st[0] = 1'b1; m_pk = 0; end
      end
    end
    #1;
    chk(reg_rdata == exp_pos(), "R6 write position", reg_rdata, exp_pos());
    chk(irq == exp_irq(), "R10 irq", 32'(irq), 32'(exp_irq()));
  endtask

  task automatic packet(input string req);
    send(8'h47, 1, 1, req);
    for (int i = 1; i < int'(m_plen); i++) send(8'(i * 7 + 3), 1, 0, req);
  endtask

  initial begin
    #(20 * 150000);
    if (!done_flag) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int unsigned seed;
    seed = $urandom(32'd2024);
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R1 reset state
    rd(0, v); chk(v == 0, "R1 run", v, 0);
    rd(1, v); chk(v == 0, "R1 base", v, 0);
    rd(3, v); chk(v == 188, "R1 pktlen", v, 188);
    rd(4, v); chk(v == 47, "R1 irq count", v, 47);
    rd(5, v); chk(v == 0, "R1 wpos", v, 0);
    rd(8, v); chk(v == 0, "R1 status", v, 0);
    chk(irq == 0, "R1 irq", 32'(irq), 0);

    wr(1, 32'h0000_1000); wr(2, 20); wr(3, 8); wr(4, 2); wr(7, 4'b1101);
    rd(1, v); chk(v == 32'h1000, "R6 base readback", v, 32'h1000);

    send(8'h47, 1, 1, "R2 stopped");
    send(8'h47, 1, 1, "R2 stopped");
    wr(0, 1);
    send(8'h12, 1, 0, "R3 junk");
    send(8'h47, 1, 0, "R3 sync without start");
    send(8'h33, 1, 1, "R3 start without sync");
    send(8'h47, 0, 1, "R3 not valid");
    packet("R4 first packet");
    send(8'h55, 1, 0, "R5 byte after packet");
    send(8'h47, 1, 0, "R5 sync without start");
    packet("R8 second packet");
    rd(8, v); chk(v == 1, "R8 status bit0", v, 1);
    packet("R4 wrap packet");
    wr(8, 1);
    rd(8, v); chk(v == 0, "R9 w1c clear", v, 0);
    chk(irq == 0, "R10 irq cleared", 32'(irq), 0);

    // R9 simultaneous set and clear of bit 2
    wr(8, 4'b0100, 1'b1);
    rd(8, v); chk(v == 4'b0100, "R9 set wins", v, 4'b0100);
    chk(irq == 1, "R10 host irq", 32'(irq), 1);
    wr(8, 4'b0100);
    rd(8, v); chk(v == 0, "R9 host cleared", v, 0);

    // R10 masked source
    wr(7, 4'b0001);
    @(negedge clk); ir_evt = 1; @(posedge clk); #1 ir_evt = 0; m_st[3] = 1'b1;
    rd(8, v); chk(v == 4'b1000, "R9 ir status", v, 4'b1000);
    chk(irq == 0, "R10 masked ir", 32'(irq), 0);
    wr(8, 4'b1000);

    // R7 restart mid packet
    send(8'h47, 1, 1, "R7 partial");
    send(8'h01, 1, 0, "R7 partial");
    send(8'h02, 1, 0, "R7 partial");
    wr(6, 1);
    rd(5, v); chk(v == 32'h1000, "R7 wpos at base", v, 32'h1000);
    send(8'h03, 1, 0, "R7 dropped tail");
    packet("R7 after restart");

    // R2 stop mid stream: position frozen
    wr(0, 0);
    send(8'h47, 1, 1, "R2 frozen");
    send(8'h99, 1, 0, "R2 frozen");
    wr(0, 1);

    // random phase
    wr(1, 32'h0002_0000); wr(2, 37); wr(3, 6); wr(4, 3); wr(7, 4'b1111); wr(6, 1);
    for (int p = 0; p < 120; p++) begin
      if ($urandom_range(3) == 0)
        for (int j = 0; j < int'($urandom_range(1, 3)); j++) begin
          logic [7:0] d;
          d = 8'($urandom_range(255));
          if (d == 8'h47) d = 8'h48;
          send(d, 1, $urandom_range(1) == 1, "R3 random junk");
        end
      send(8'h47, 1, 1, "R4 random sync");
      for (int i = 1; i < int'(m_plen); i++) begin
        if ($urandom_range(4) == 0) send(8'h00, 0, 0, "R2 random gap");
        send(8'($urandom_range(255)), 1, 0, "R5 random body");
      end
      if ($urandom_range(9) == 0) wr(6, 1);
      if ($urandom_range(5) == 0) wr(8, 1);
    end
    rd(5, v); chk(v == exp_pos(), "R6 final wpos", v, exp_pos());

    done_flag = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule